// File: doc/BRIEF.md
# Chip-Select-Free SPI Frame Slave

This block is an SPI slave for a link that has no chip-select wire. A bit-banged master clocks exactly 256 bits in each direction per exchange. The request shifts in on MOSI while the reply shifts out on MISO. Only the serial clock tells the slave where a frame starts. When SCK has shown no edge for a programmable number of system-clock cycles, the slave drops any partial frame and returns to the start-of-frame state. It also forces that state after every complete frame, so a single clock glitch costs at most one frame.

SCK and MOSI are oversampled in the system-clock domain through two-flop synchronisers, and the edges are taken from the synchronised copies. The system clock must run at least 8 times faster than SCK. The reply frame is written through a load port and held in the block, and it is sent again for every frame until a new one is loaded. A supervision timer watches for good frames. When none arrives within a long window, it raises a link-lost level and emits a fixed-width reset pulse that can restart a stalled master.

Top module: `spi_gap_slave`

## Requirements
- R1: After the 256th rising SCK edge of a frame, rx_frame_o holds the 256 MOSI bits with the first bit received at bit 255. rx_valid_o is high for exactly one system cycle, in the third system cycle after the SCK rise is driven. rx_frame_o changes only together with rx_valid_o.
- R2: The interface uses SPI mode 0. MOSI is sampled on rising SCK edges. MISO changes only after falling edges and sends the held reply frame MSB first. Bit 255 is on MISO before the first rising edge.
- R3: When SCK has been idle for GAP_CYCLES system cycles, a partial frame is dropped without an rx_valid_o pulse. The next full frame is then received and sent correctly aligned.
- R4: A frame cut short by the idle gap sets frame_err_o. The flag stays set until reset, including across later good frames.
- R5: After a complete frame, the bit counter is cleared and the transmit shifter is reloaded from the held reply. The trailing falling edge does not shift it, so the next frame sends the same reply again if nothing new was loaded.
- R6: A tx_load_i pulse while no frame is in progress sets the reply for the next frame. A pulse during a frame leaves that frame's MISO bits unchanged and takes effect from the next frame.
- R7: If no good frame completes for SUPERV_CYCLES cycles, link_lost_o and master_rst_o rise SUPERV_CYCLES+1 cycles after the last rx_valid_o cycle. master_rst_o stays high for exactly RST_PULSE_CYCLES cycles and repeats once per further window. link_lost_o clears in the cycle after the next rx_valid_o.
- R8: Under reset, every output is low and rx_frame_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| miso_o | output | 1 | Serial data to the master, registered |
| tx_frame_i | input | 8*FRAME_BYTES | Reply frame, bit 255 sent first |
| tx_load_i | input | 1 | One-cycle strobe that captures tx_frame_i |
| rx_frame_o | output | 8*FRAME_BYTES | Last complete request frame |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_frame_o |
| frame_err_o | output | 1 | Sticky flag for a truncated frame |
| link_lost_o | output | 1 | High from supervision expiry until the next good frame |
| master_rst_o | output | 1 | Reset pulse toward the master |

## Verification
Each SCK or MOSI change reaches the frame logic two synchroniser stages plus one edge register later. rx_valid_o is therefore due in the third system cycle after the final SCK rise, and the bench compares the cycle stamp of the strobe with the stamp of that rise. MISO settles a few cycles after each falling edge, and the bench reads it half an SCK period later, just before the next rise. The supervision pulse is checked at exactly SUPERV_CYCLES+1 cycles after the last strobe, and its width is counted cycle by cycle. The error flag and the gap resync are checked only after a wait well past GAP_CYCLES.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
  // Edge events derived from the oversampled serial clock
  typedef struct packed {
    logic rise;   // synchronised SCK went 0 -> 1
    logic fall;   // synchronised SCK went 1 -> 0
    logic data;   // synchronised MOSI
  } spi_evt_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_i,
  input  logic                  mosi_i,
  output spi_gap_pkg::spi_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] sck_pipe;
  logic [SYNC_STAGES-1:0] mosi_pipe;
  logic                   sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_last  <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], sck_i};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
      sck_last  <= sck_pipe[SYNC_STAGES-1];
    end
  end

  always_comb begin
    evt_o.rise = sck_pipe[SYNC_STAGES-1] & ~sck_last;
    evt_o.fall = ~sck_pipe[SYNC_STAGES-1] & sck_last;
    evt_o.data = mosi_pipe[SYNC_STAGES-1];
  end
endmodule

// File: rtl/spi_idle_timer.sv
module spi_idle_timer #(
  parameter int GAP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic gap_hit
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  logic [GW-1:0] idle_cnt;

  // Counts quiet cycles; fires once when the threshold is reached
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      gap_hit  <= 1'b0;
    end else begin
      gap_hit <= !edge_seen && (idle_cnt == GW'(GAP_CYCLES - 1));
      if (edge_seen)
        idle_cnt <= '0;
      else if (idle_cnt != GW'(GAP_CYCLES))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int FRAME_BYTES = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  spi_gap_pkg::spi_evt_t      evt,
  input  logic                       gap_hit,
  input  logic [8*FRAME_BYTES-1:0]   tx_frame_i,
  input  logic                       tx_load_i,
  output logic                       miso_o,
  output logic [8*FRAME_BYTES-1:0]   rx_frame_o,
  output logic                       rx_valid_o,
  output logic                       frame_err_o
);
  localparam int FB = 8 * FRAME_BYTES;
  localparam int CW = $clog2(FB);

  logic [CW-1:0] bit_cnt;
  logic [FB-1:0] rx_shift;
  logic [FB-1:0] tx_shift;
  logic [FB-1:0] tx_hold;
  logic [FB-1:0] tx_next_frame;
  logic          in_frame;

  assign in_frame      = (bit_cnt != '0);
  assign tx_next_frame = tx_load_i ? tx_frame_i : tx_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt     <= '0;
      rx_shift    <= '0;
      tx_shift    <= '0;
      tx_hold     <= '0;
      rx_frame_o  <= '0;
      rx_valid_o  <= 1'b0;
      frame_err_o <= 1'b0;
      miso_o      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      miso_o     <= tx_shift[FB-1];
      if (tx_load_i)
        tx_hold <= tx_frame_i;

      if (evt.rise) begin
        if (bit_cnt == CW'(FB - 1)) begin
          // last bit: publish and force resync
          rx_frame_o <= {rx_shift[FB-2:0], evt.data};
          rx_valid_o <= 1'b1;
          bit_cnt    <= '0;
          rx_shift   <= '0;
          tx_shift   <= tx_next_frame;
        end else begin
          rx_shift <= {rx_shift[FB-2:0], evt.data};
          bit_cnt  <= bit_cnt + 1'b1;
        end
      end else if (evt.fall && in_frame) begin
        tx_shift <= {tx_shift[FB-2:0], 1'b0};
      end else if (gap_hit) begin
        if (in_frame)
          frame_err_o <= 1'b1;
        bit_cnt  <= '0;
        rx_shift <= '0;
        tx_shift <= tx_next_frame;
      end else if (tx_load_i && !in_frame) begin
        tx_shift <= tx_frame_i;
      end
    end
  end
endmodule

// File: rtl/spi_link_watch.sv
module spi_link_watch #(
  parameter int SUPERV_CYCLES    = 50_000_000,
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_ok,
  output logic link_lost_o,
  output logic master_rst_o
);
  localparam int SW = $clog2(SUPERV_CYCLES + 1);
  localparam int PW = $clog2(RST_PULSE_CYCLES + 1);

  logic [SW-1:0] quiet_cnt;
  logic [PW-1:0] pulse_left;
  logic          expire;

  assign expire = !frame_ok && (quiet_cnt == SW'(SUPERV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt    <= '0;
      pulse_left   <= '0;
      link_lost_o  <= 1'b0;
      master_rst_o <= 1'b0;
    end else begin
      master_rst_o <= expire || (pulse_left > PW'(1));
      if (frame_ok) begin
        quiet_cnt   <= '0;
        link_lost_o <= 1'b0;
      end else if (expire) begin
        quiet_cnt   <= '0;
        link_lost_o <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
      if (expire)
        pulse_left <= PW'(RST_PULSE_CYCLES);
      else if (pulse_left != '0)
        pulse_left <= pulse_left - 1'b1;
    end
  end
endmodule

// File: rtl/spi_gap_slave.sv
module spi_gap_slave #(
  parameter int FRAME_BYTES      = 32,
  parameter int GAP_CYCLES       = 64,
  parameter int SUPERV_CYCLES    = 50_000_000,
  parameter int RST_PULSE_CYCLES = 16,
  parameter int SYNC_STAGES      = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sck_i,
  input  logic                     mosi_i,
  output logic                     miso_o,
  input  logic [8*FRAME_BYTES-1:0] tx_frame_i,
  input  logic                     tx_load_i,
  output logic [8*FRAME_BYTES-1:0] rx_frame_o,
  output logic                     rx_valid_o,
  output logic                     frame_err_o,
  output logic                     link_lost_o,
  output logic                     master_rst_o
);
  spi_gap_pkg::spi_evt_t evt;
  logic                  gap_hit;

  spi_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .evt_o  (evt)
  );

  spi_idle_timer #(.GAP_CYCLES(GAP_CYCLES)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (evt.rise | evt.fall),
    .gap_hit   (gap_hit)
  );

  spi_frame_engine #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .gap_hit     (gap_hit),
    .tx_frame_i  (tx_frame_i),
    .tx_load_i   (tx_load_i),
    .miso_o      (miso_o),
    .rx_frame_o  (rx_frame_o),
    .rx_valid_o  (rx_valid_o),
    .frame_err_o (frame_err_o)
  );

  spi_link_watch #(
    .SUPERV_CYCLES    (SUPERV_CYCLES),
    .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
  ) u_watch (
    .clk          (clk),
    .rst          (rst),
    .frame_ok     (rx_valid_o),
    .link_lost_o  (link_lost_o),
    .master_rst_o (master_rst_o)
  );
endmodule

// File: rtl/spi_gap_slave_chk.sv
module spi_gap_slave_chk #(
  parameter int FRAME_BYTES      = 32,
  parameter int RST_PULSE_CYCLES = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [8*FRAME_BYTES-1:0] rx_frame_o,
  input logic                     rx_valid_o,
  input logic                     frame_err_o,
  input logic                     link_lost_o,
  input logic                     master_rst_o
);
  int unsigned hi_run;

  // R1: strobe lasts a single cycle
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R1: received data moves only with its strobe
  p_rxdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_frame_o) |-> rx_valid_o);

  // R4: error flag never clears outside reset
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> frame_err_o);

  // R7: a new reset pulse starts only with link lost
  p_rst_with_lost_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(master_rst_o) |-> link_lost_o);

  // R7: a good frame clears link lost
  p_lost_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !link_lost_o);

  // R7: pulse width bounded, checked with a run counter
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 0;
    end else begin
      hi_run <= master_rst_o ? hi_run + 1 : 0;
      p_rst_width_r7: assert (hi_run <= RST_PULSE_CYCLES);
    end
  end
endmodule

bind spi_gap_slave spi_gap_slave_chk #(
  .FRAME_BYTES      (FRAME_BYTES),
  .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_frame_o   (rx_frame_o),
  .rx_valid_o   (rx_valid_o),
  .frame_err_o  (frame_err_o),
  .link_lost_o  (link_lost_o),
  .master_rst_o (master_rst_o)
);

// File: tb/spi_gap_slave_tb.sv
`timescale 1ns/1ps
module spi_gap_slave_tb;
  localparam int FB    = 256;
  localparam int GAP   = 64;
  localparam int SUP   = 12000;
  localparam int PULSE = 16;
  localparam int HALF  = 8;   // SCK half period in system cycles
  localparam int NV    = 4;

  localparam logic [FB-1:0] RXV [NV] = '{
    {8{32'h48656C6C}}, {8{32'hA5C3_0FF0}}, {FB{1'b1}}, {4{64'h0123_4567_89AB_CDEF}}};
  localparam logic [FB-1:0] TXV [NV] = '{
    {8{32'h5A5A_1234}}, {FB{1'b0}}, {16{16'h8001}}, {8{32'hDEAD_BEEF}}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sck = 1'b0;
  logic          mosi = 1'b0;
  logic          miso;
  logic [FB-1:0] tx_frame = '0;
  logic          tx_load = 1'b0;
  logic [FB-1:0] rx_frame;
  logic          rx_valid, frame_err, link_lost, master_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int vcnt = 0;
  int vlast = 0;
  int last_rise = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  spi_gap_slave #(
    .GAP_CYCLES(GAP), .SUPERV_CYCLES(SUP), .RST_PULSE_CYCLES(PULSE)
  ) u_dut (
    .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .miso_o(miso),
    .tx_frame_i(tx_frame), .tx_load_i(tx_load), .rx_frame_o(rx_frame),
    .rx_valid_o(rx_valid), .frame_err_o(frame_err), .link_lost_o(link_lost),
    .master_rst_o(master_rst)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rx_valid) begin vcnt++; vlast = cyc; end

  task automatic check(input bit ok, input string tag, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [FB-1:0] d);
    @(negedge clk);
    tx_frame = d;
    tx_load  = 1'b1;
    @(negedge clk);
    tx_load  = 1'b0;
  endtask

  // Master: mode 0, MSB first; samples MISO just before each rise
  task automatic send_bits(input logic [FB-1:0] d, input int nbits, output logic [FB-1:0] got);
    got = '0;
    for (int b = 0; b < nbits; b++) begin
      mosi = d[FB-1-b];
      wait_cyc(HALF);
      got[FB-1-b] = miso;
      sck = 1'b1;
      last_rise = cyc;
      wait_cyc(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FB-1:0] got;
    int v0;
    int hi;
    wait_cyc(4);
    // R8: reset state
    check(!miso && !rx_valid && !frame_err && !link_lost && !master_rst, "R8 outputs low",
          {miso, rx_valid, frame_err, link_lost, master_rst}, '0);
    check(rx_frame == '0, "R8 rx_frame zero", rx_frame, '0);
    @(negedge clk) rst = 1'b0;

    // Vector table: R1 data/timing, R2 MISO order, R6 idle load
    for (int i = 0; i < NV; i++) begin
      load_tx(TXV[i]);
      wait_cyc(6);
      v0 = vcnt;
      send_bits(RXV[i], FB, got);
      wait_cyc(4);
      check(vcnt == v0 + 1, "R1 one strobe per frame", FB'(vcnt - v0), FB'(1));
      check(vlast - last_rise == 3, "R1 strobe latency", FB'(vlast - last_rise), FB'(3));
      check(rx_frame == RXV[i], "R1 rx data", rx_frame, RXV[i]);
      check(got == TXV[i], "R2 R6 miso data", got, TXV[i]);
      check(!frame_err && !link_lost, "R4 R7 no flags", {frame_err, link_lost}, '0);
    end

    // R5: reply resent without new load
    send_bits(RXV[1], FB, got);
    wait_cyc(4);
    check(got == TXV[3], "R5 reload after frame", got, TXV[3]);
    check(rx_frame == RXV[1], "R5 rx next frame aligned", rx_frame, RXV[1]);

    // R3/R4: truncated frame, gap, then aligned full frame
    v0 = vcnt;
    send_bits(RXV[2], 100, got);
    wait_cyc(GAP + 12);
    check(vcnt == v0, "R3 partial dropped", FB'(vcnt - v0), '0);
    check(frame_err == 1'b1, "R4 error set", FB'(frame_err), FB'(1));
    send_bits(RXV[0], FB, got);
    wait_cyc(4);
    check(rx_frame == RXV[0], "R3 resync rx", rx_frame, RXV[0]);
    check(got == TXV[3], "R3 resync miso", got, TXV[3]);
    check(frame_err == 1'b1, "R4 error sticky", FB'(frame_err), FB'(1));

    // R6: load during a frame is deferred
    fork
      send_bits(RXV[3], FB, got);
      begin
        wait_cyc(1000);
        tx_frame = TXV[0];
        tx_load  = 1'b1;
        wait_cyc(1);
        tx_load  = 1'b0;
      end
    join
    wait_cyc(4);
    check(got == TXV[3], "R6 current frame unchanged", got, TXV[3]);
    send_bits(RXV[2], FB, got);
    wait_cyc(4);
    check(got == TXV[0], "R6 deferred load applied", got, TXV[0]);

    // R7: supervision expiry, pulse width, clearing
    while (cyc < vlast + SUP - 20) @(negedge clk);
    check(!link_lost && !master_rst, "R7 quiet before window", {link_lost, master_rst}, '0);
    while (cyc < vlast + SUP + 1) @(negedge clk);
    check(link_lost && master_rst, "R7 expiry edge", {link_lost, master_rst}, 2'b11);
    hi = 0;
    for (int k = 0; k < 100; k++) begin
      if (master_rst) hi++;
      @(negedge clk);
    end
    check(hi == PULSE, "R7 pulse width", FB'(hi), FB'(PULSE));
    check(link_lost == 1'b1, "R7 lost holds", FB'(link_lost), FB'(1));
    send_bits(RXV[1], FB, got);
    wait_cyc(4);
    check(!link_lost, "R7 lost cleared", FB'(link_lost), '0);

    // R8/R4: reset clears sticky error
    @(negedge clk) rst = 1'b1;
    wait_cyc(3);
    check(!frame_err && rx_frame == '0, "R8 R4 reset clears", {frame_err, rx_frame[7:0]}, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule